// File: doc/BRIEF.md
# Hardwired Single-Accumulator Processor Core

This block is a small 16-bit processor built around one accumulator and a 4096-word by 16-bit internal memory. A 4-bit step counter produces one timing pulse per clock cycle. Each control action is a decoded opcode line combined with one of these pulses. The registers exchange data over one shared 16-bit bus. A 3-bit select code, built from one-hot source requests, picks which register or the memory read port drives that bus.

Software is placed in memory through a preload port while the core is stopped. A one-cycle start pulse begins execution at the current program address, which is zero after reset. The core then fetches, decodes and executes instructions until it meets a halt instruction. Results are read back through the same port. Input-output instructions are not executed here. The core announces each one with a one-cycle strobe and its 12-bit operation field, so that a neighbouring I/O block can act on it.

Top module: `acc_cpu`

## Requirements
- R1: While reset is low, and after it is released, the core is stopped (`running`=0), the step counter is zero and the program address is zero.
- R2: A start pulse while stopped raises `running`. The halt instruction 0x7001 lowers it at the end of its execution step.
- R3: Word format: bit 15 is the indirect flag, bits 14:12 the opcode and bits 11:0 the address. Opcode 2 loads the accumulator from the addressed word and opcode 3 stores the accumulator there. A memory write happens only in an execution step (step 4 or later).
- R4: With bit 15 set on opcodes 0 to 6, the word at the address field gives the operand address (one level of indirection).
- R5: Opcode 0 ANDs the operand into the accumulator. Opcode 1 adds it and places the carry out in the extension bit E.
- R6: Opcode 4 jumps to the effective address. Opcode 5 writes the return address to the effective address and continues at the effective address plus one.
- R7: Opcode 6 increments the operand in memory and skips the next instruction when the result is zero.
- R8: Register operations (opcode 7, bit 15 clear) are selected by one bit each: bit 11 clears AC, bit 10 clears E, bit 9 complements AC, bit 8 complements E.
- R9: Bit 7 rotates {AC,E} right (E enters AC bit 15, AC bit 0 enters E). Bit 6 rotates left (E enters AC bit 0, AC bit 15 enters E).
- R10: Bit 5 increments AC. Bits 4, 3, 2 and 1 skip the next instruction when AC is positive, AC is negative, AC is zero and E is zero, respectively.
- R11: Instruction lengths in cycles: AND/ADD/LDA/BSA take 6, STA/BUN take 5, ISZ takes 7, register and I/O instructions take 4.
- R12: At most one bus source is active per cycle. A 12-bit register placed on the bus has its upper 4 bits zero, so a stored return address reads back zero-extended.
- R13: Opcode 7 with bit 15 set raises `io_strobe` for one cycle with `io_cmd` equal to bits 11:0 and ends the instruction.
- R14: While stopped, no register changes. A later start resumes at the instruction after the halt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that starts execution |
| running | output | 1 | High while the core executes |
| ld_en | input | 1 | Preload write enable |
| ld_addr | input | 12 | Preload/inspect address |
| ld_data | input | 16 | Preload write data |
| ld_rdata | output | 16 | Combinational read of the word at `ld_addr` |
| io_strobe | output | 1 | One-cycle pulse for an I/O instruction |
| io_cmd | output | 12 | Operation field of that I/O instruction |

## Verification
The assertions assume several things about the inputs. `start` is pulsed only while the core is stopped. The preload port writes only while the core is stopped, so it never collides with an execution-step write. Each register-reference word sets exactly one operation bit, because the bus and register decode assume a single action per step. The stimulus respects this: every scenario resets the core, loads memory with `running` low, issues one start pulse, and waits for `running` to fall before inspecting memory. Every program uses only single-bit register operations.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int WORD_W  = 16;
  localparam int ADDR_W  = 12;
  localparam int SC_W    = 4;
  localparam int N_PULSE = 7;   // steps T0..T6 are used
  localparam int N_SRC   = 8;   // select code 0 means no source
  localparam int SEL_W   = $clog2(N_SRC);

  typedef enum logic [SEL_W-1:0] {
    SRC_NONE = 3'd0, SRC_AR = 3'd1, SRC_PC = 3'd2, SRC_DR = 3'd3,
    SRC_AC   = 3'd4, SRC_IR = 3'd5, SRC_TR = 3'd6, SRC_MEM = 3'd7
  } bus_src_e;

  function automatic logic [WORD_W:0] word_add(input logic [WORD_W-1:0] a,
                                               input logic [WORD_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  // returns {new_e, new_ac}
  function automatic logic [WORD_W:0] rot_right(input logic e,
                                                input logic [WORD_W-1:0] a);
    return {a[0], e, a[WORD_W-1:1]};
  endfunction

  function automatic logic [WORD_W:0] rot_left(input logic e,
                                               input logic [WORD_W-1:0] a);
    return {a[WORD_W-1], a[WORD_W-2:0], e};
  endfunction
endpackage

// File: rtl/acc_seq_timer.sv
module acc_seq_timer #(
  parameter int SC_W    = 4,
  parameter int N_PULSE = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               clr,
  output logic [SC_W-1:0]    sc,
  output logic [N_PULSE-1:0] t
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sc <= '0;
    else if (run) begin
      if (clr)       sc <= '0;
      else           sc <= sc + 1'b1;
    end
  end

  for (genvar i = 0; i < N_PULSE; i++) begin : g_pulse
    assign t[i] = run && (sc == SC_W'(i));
  end
endmodule

// File: rtl/acc_bus_sel.sv
module acc_bus_sel #(
  parameter int W     = 16,
  parameter int N_SRC = 8,
  parameter int SEL_W = 3
) (
  input  logic [N_SRC-1:1] req,
  input  logic [W-1:0]     src [1:N_SRC-1],
  output logic [SEL_W-1:0] sel,
  output logic [W-1:0]     bus
);
  // OR-encoder: no priority, relies on one-hot requests
  always_comb begin
    sel = '0;
    for (int i = 1; i < N_SRC; i++)
      if (req[i]) sel = sel | SEL_W'(i);
  end

  always_comb begin
    bus = '0;
    for (int i = 1; i < N_SRC; i++)
      if (sel == SEL_W'(i)) bus = src[i];
  end
endmodule

// File: rtl/acc_mem.sv
module acc_mem #(
  parameter int AW = 12,
  parameter int W  = 16
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [W-1:0]  ld_data,
  output logic [W-1:0]  ld_rdata
);
  localparam int DEPTH = 2 ** AW;
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (ld_en)   store[ld_addr] <= ld_data;
    else if (we) store[addr]    <= wdata;
  end

  assign rdata    = store[addr];
  assign ld_rdata = store[ld_addr];
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              running,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  output logic [WORD_W-1:0] ld_rdata,
  output logic              io_strobe,
  output logic [ADDR_W-1:0] io_cmd
);
  localparam int EXT_W = WORD_W - ADDR_W;

  logic [WORD_W-1:0] ac, dr, ir, bus, mem_rd, ac_nx;
  logic [ADDR_W-1:0] ar, pc;
  logic              e, e_nx, ir_i, s_run;
  logic [SC_W-1:0]   sc;
  logic [N_PULSE-1:0] t;
  logic [7:0]        d;
  logic [N_SRC-1:1]  bus_req;
  logic [SEL_W-1:0]  bus_sel;
  logic [WORD_W-1:0] src [1:N_SRC-1];

  // named control events
  logic rd_op, r_op, p_op, ind_step, mem_we, sc_clr;
  logic skip_hit, pc_inc, halt_req, ar_ld, pc_ld, dr_ld;

  assign d        = 8'd1 << ir[14:12];
  assign rd_op    = d[0] | d[1] | d[2] | d[6];
  assign r_op     = t[3] & d[7] & ~ir_i;
  assign p_op     = t[3] & d[7] & ir_i;
  assign ind_step = t[3] & ~d[7] & ir_i;
  assign halt_req = r_op & ir[0];

  assign skip_hit = (t[6] & d[6] & (dr == '0))
                  | (r_op & ((ir[4] & ~ac[WORD_W-1]) | (ir[3] & ac[WORD_W-1])
                           | (ir[2] & (ac == '0))   | (ir[1] & ~e)));
  assign pc_inc   = t[1] | skip_hit;
  assign sc_clr   = (t[5] & (d[0] | d[1] | d[2] | d[5]))
                  | (t[4] & (d[3] | d[4])) | (t[6] & d[6]) | r_op | p_op;
  assign mem_we   = (t[4] & (d[3] | d[5])) | (t[6] & d[6]);

  // bus source requests, one per select code
  assign bus_req[SRC_AR]  = (t[4] & d[4]) | (t[5] & d[5]);
  assign bus_req[SRC_PC]  = t[0] | (t[4] & d[5]);
  assign bus_req[SRC_DR]  = t[6] & d[6];
  assign bus_req[SRC_AC]  = t[4] & d[3];
  assign bus_req[SRC_IR]  = t[2];
  assign bus_req[SRC_TR]  = 1'b0;
  assign bus_req[SRC_MEM] = t[1] | ind_step | (t[4] & rd_op);

  assign src[SRC_AR]  = {{EXT_W{1'b0}}, ar};
  assign src[SRC_PC]  = {{EXT_W{1'b0}}, pc};
  assign src[SRC_DR]  = dr;
  assign src[SRC_AC]  = ac;
  assign src[SRC_IR]  = ir;
  assign src[SRC_TR]  = '0;
  assign src[SRC_MEM] = mem_rd;

  assign ar_ld = t[0] | t[2] | ind_step;
  assign pc_ld = bus_req[SRC_AR];
  assign dr_ld = t[4] & rd_op;

  acc_seq_timer #(.SC_W(SC_W), .N_PULSE(N_PULSE)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(s_run), .clr(sc_clr), .sc(sc), .t(t)
  );

  acc_bus_sel #(.W(WORD_W), .N_SRC(N_SRC), .SEL_W(SEL_W)) u_bus (
    .req(bus_req), .src(src), .sel(bus_sel), .bus(bus)
  );

  acc_mem #(.AW(ADDR_W), .W(WORD_W)) u_mem (
    .clk(clk), .addr(ar), .we(mem_we), .wdata(bus), .rdata(mem_rd),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data), .ld_rdata(ld_rdata)
  );

  // accumulator and extension bit next state
  always_comb begin
    ac_nx = ac;
    e_nx  = e;
    if (t[5] & d[0]) ac_nx = ac & dr;
    if (t[5] & d[1]) {e_nx, ac_nx} = word_add(ac, dr);
    if (t[5] & d[2]) ac_nx = dr;
    if (r_op) begin
      if (ir[11])     ac_nx = '0;
      else if (ir[9]) ac_nx = ~ac;
      else if (ir[7]) {e_nx, ac_nx} = rot_right(e, ac);
      else if (ir[6]) {e_nx, ac_nx} = rot_left(e, ac);
      else if (ir[5]) ac_nx = ac + 1'b1;
      if (ir[10])     e_nx = 1'b0;
      else if (ir[8]) e_nx = ~e;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_run <= 1'b0;
      ar    <= '0;
      pc    <= '0;
      dr    <= '0;
      ir    <= '0;
      ir_i  <= 1'b0;
      ac    <= '0;
      e     <= 1'b0;
    end else begin
      if (start)     s_run <= 1'b1;
      if (halt_req)  s_run <= 1'b0;
      if (ar_ld)     ar <= bus[ADDR_W-1:0];
      else if (t[4] & d[5]) ar <= ar + 1'b1;
      if (pc_ld)     pc <= bus[ADDR_W-1:0];
      else if (pc_inc) pc <= pc + 1'b1;
      if (t[1])      ir <= bus;
      if (t[2])      ir_i <= ir[WORD_W-1];
      if (dr_ld)     dr <= bus;
      else if (t[5] & d[6]) dr <= dr + 1'b1;
      ac <= ac_nx;
      e  <= e_nx;
    end
  end

  assign running   = s_run;
  assign io_strobe = p_op;
  assign io_cmd    = ir[ADDR_W-1:0];
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_cpu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              running,
  input logic [SC_W-1:0]   sc,
  input logic [N_SRC-1:1]  bus_req,
  input logic [SEL_W-1:0]  bus_sel,
  input logic [WORD_W-1:0] bus,
  input logic [ADDR_W-1:0] pc,
  input logic [WORD_W-1:0] ac,
  input logic              mem_we,
  input logic              r_op,
  input logic              halt_req,
  input logic              io_strobe
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (!running && pc == '0 && sc == '0));

  assert_start_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !running) |=> running);

  assert_halt_stops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> (!running && sc == '0));

  assert_write_in_exec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (sc >= SC_W'(4)));

  assert_step_limit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (sc <= SC_W'(6)));

  assert_regop_one_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    r_op |=> (sc == '0));

  assert_bus_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_req));

  assert_bus_zext_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel == SRC_AR || bus_sel == SRC_PC) |-> (bus[WORD_W-1:ADDR_W] == '0));

  assert_io_ends_R13: assert property (@(posedge clk) disable iff (!rst_n)
    io_strobe |=> (sc == '0));

  assert_idle_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> ($stable(pc) && $stable(ac)));
endmodule

bind acc_cpu acc_cpu_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .running(running), .sc(sc),
  .bus_req(bus_req), .bus_sel(bus_sel), .bus(bus), .pc(pc), .ac(ac),
  .mem_we(mem_we), .r_op(r_op), .halt_req(halt_req), .io_strobe(io_strobe)
);

// File: tb/acc_cpu_tb_top.sv
module acc_cpu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_LIMIT  = 2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        running;
  logic        ld_en = 1'b0;
  logic [11:0] ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [15:0] ld_rdata;
  logic        io_strobe;
  logic [11:0] io_cmd;

  int n_checks = 0;
  int n_errors = 0;
  int io_hits = 0;
  logic [11:0] io_last = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cpu dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .running(running),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data), .ld_rdata(ld_rdata),
    .io_strobe(io_strobe), .io_cmd(io_cmd)
  );

  always @(negedge clk) begin
    if (io_strobe) begin
      io_hits++;
      io_last = io_cmd;
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic poke(input logic [11:0] a, input logic [15:0] v);
    ld_en = 1'b1; ld_addr = a; ld_data = v;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic peek(input logic [11:0] a, output logic [15:0] v);
    ld_addr = a;
    #1;
    v = ld_rdata;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 32; i++) poke(12'(i), 16'h0000);
    for (int i = 0; i < 32; i++) poke(12'h100 + 12'(i), 16'h0000);
  endtask

  task automatic run_prog(output int cycles);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 0;
    while (running && cycles < RUN_LIMIT) begin
      cycles++;
      @(negedge clk);
    end
  endtask

  task automatic expect_word(input string tag, input logic [11:0] a, input logic [15:0] exp);
    logic [15:0] v;
    peek(a, v);
    check(tag, v, exp);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 running after reset", {15'd0, running}, 16'd0);
    repeat (4) @(negedge clk);
    check("R1 stays stopped without start", {15'd0, running}, 16'd0);
    check("R1 no io strobe", {15'd0, io_strobe}, 16'd0);
  endtask

  task automatic t_load_store();
    int n;
    do_reset(); clear_mem();
    poke(0, 16'h2100); poke(1, 16'h3101); poke(2, 16'h7001);
    poke(12'h100, 16'h1234);
    run_prog(n);
    check("R2 halted", {15'd0, running}, 16'd0);
    expect_word("R3 LDA/STA copy", 12'h101, 16'h1234);
    check("R11 LDA+STA+HLT cycles", 16'(n), 16'd15);
  endtask

  task automatic t_indirect();
    int n;
    do_reset(); clear_mem();
    poke(0, 16'hA100); poke(1, 16'h3101); poke(2, 16'h7001);
    poke(12'h100, 16'h0110); poke(12'h110, 16'hBEEF);
    run_prog(n);
    expect_word("R4 indirect load", 12'h101, 16'hBEEF);
    check("R11 indirect no extra cycles", 16'(n), 16'd15);
  endtask

  task automatic t_and_add();
    int n;
    do_reset(); clear_mem();
    poke(0, 16'h2100); poke(1, 16'h0101); poke(2, 16'h3110);
    poke(3, 16'h1102); poke(4, 16'h3111); poke(5, 16'h7040);
    poke(6, 16'h3112); poke(7, 16'h7001);
    poke(12'h100, 16'hF0F0); poke(12'h101, 16'h3CFF); poke(12'h102, 16'hF000);
    run_prog(n);
    expect_word("R5 AND result", 12'h110, 16'h30F0);
    expect_word("R5 ADD sum", 12'h111, 16'h20F0);
    expect_word("R5 ADD carry into E seen by rotate", 12'h112, 16'h41E1);
    check("R11 AND/ADD cycles", 16'(n), 16'd41);
  endtask

  task automatic t_branch();
    int n;
    do_reset(); clear_mem();
    poke(0, 16'h4005); poke(5, 16'h5100);
    poke(12'h101, 16'h2110); poke(12'h102, 16'h3111); poke(12'h103, 16'h7001);
    poke(12'h110, 16'h5555);
    run_prog(n);
    expect_word("R6 BSA return address (R12 zero-extended)", 12'h100, 16'h0006);
    expect_word("R6 continue after BSA target", 12'h111, 16'h5555);
    check("R11 BUN+BSA cycles", 16'(n), 16'd26);
  endtask

  task automatic t_isz();
    int n;
    do_reset(); clear_mem();
    poke(0, 16'h6100); poke(1, 16'h7001); poke(2, 16'h6101);
    poke(3, 16'h2102); poke(4, 16'h3103); poke(5, 16'h7001);
    poke(12'h100, 16'hFFFF); poke(12'h101, 16'h0005); poke(12'h102, 16'hABCD);
    run_prog(n);
    expect_word("R7 ISZ wrap to zero", 12'h100, 16'h0000);
    expect_word("R7 ISZ plain increment", 12'h101, 16'h0006);
    expect_word("R7 skip taken on zero", 12'h103, 16'hABCD);
    check("R11 ISZ cycles", 16'(n), 16'd29);
  endtask

  task automatic t_regops();
    int n;
    do_reset(); clear_mem();
    poke(0, 16'h2100); poke(1, 16'h7080); poke(2, 16'h3110);
    poke(3, 16'h7040); poke(4, 16'h3111); poke(5, 16'h7200);
    poke(6, 16'h3112); poke(7, 16'h7100); poke(8, 16'h7800);
    poke(9, 16'h7040); poke(10, 16'h3113); poke(11, 16'h7001);
    poke(12'h100, 16'h8001);
    run_prog(n);
    expect_word("R9 CIR through E", 12'h110, 16'h4000);
    expect_word("R9 CIL through E", 12'h111, 16'h8001);
    expect_word("R8 CMA", 12'h112, 16'h7FFE);
    expect_word("R8 CME then CLA", 12'h113, 16'h0001);
    check("R11 register op cycles", 16'(n), 16'd54);
  endtask

  task automatic t_skips();
    int n;
    do_reset(); clear_mem();
    poke(0, 16'h2100); poke(1, 16'h7010); poke(2, 16'h7001);
    poke(3, 16'h7008); poke(4, 16'h3110); poke(5, 16'h7800);
    poke(6, 16'h7004); poke(7, 16'h7001); poke(8, 16'h7400);
    poke(9, 16'h7002); poke(10, 16'h7001); poke(11, 16'h7020);
    poke(12, 16'h3111); poke(13, 16'h7001);
    poke(12'h100, 16'h0003);
    run_prog(n);
    expect_word("R10 SPA skip and SNA no skip", 12'h110, 16'h0003);
    expect_word("R10 SZA/SZE skips, INC (R8 CLA/CLE)", 12'h111, 16'h0001);
    check("R11 skip program cycles", 16'(n), 16'd48);
  endtask

  task automatic t_io();
    int n;
    do_reset(); clear_mem();
    poke(0, 16'hF400); poke(1, 16'h7001);
    io_hits = 0;
    run_prog(n);
    check("R13 one io strobe", 16'(io_hits), 16'd1);
    check("R13 io field", {4'd0, io_last}, 16'h0400);
    check("R11 io instruction cycles", 16'(n), 16'd8);
  endtask

  task automatic t_resume();
    int n;
    do_reset(); clear_mem();
    poke(0, 16'h7001); poke(1, 16'h2100); poke(2, 16'h3101); poke(3, 16'h7001);
    poke(12'h100, 16'h0C0C);
    run_prog(n);
    check("R2 first halt cycles", 16'(n), 16'd4);
    repeat (5) @(negedge clk);
    check("R14 still stopped", {15'd0, running}, 16'd0);
    expect_word("R14 nothing executed while stopped", 12'h101, 16'h0000);
    run_prog(n);
    expect_word("R14 resumed after halt", 12'h101, 16'h0C0C);
    check("R14 resumed cycles", 16'(n), 16'd15);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_load_store();
    t_indirect();
    t_and_add();
    t_branch();
    t_isz();
    t_regops();
    t_skips();
    t_io();
    t_resume();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule